// File: doc/BRIEF.md
# Toroidal Neighbour Shift Network

This block moves one bit per processing element across a square grid of single-bit elements. Element indices run row by row: row r holds indices r*SIDE up to (r+1)*SIDE-1. A 3-bit direction code selects one of eight moves. Each element then receives the bit held by its neighbour in that direction. The grid wraps at every edge, so it behaves as a torus.

A move is built from two stages. A vertical stage rotates whole rows by one step. A horizontal stage then rotates bits within each row by one step. A diagonal move is the vertical step followed by the horizontal step, and both steps wrap. The result is captured in a register on the rising clock edge. With the default SIDE of 4 the grid has 16 elements, so both the input and the output vectors are 16 bits wide.

Top module: `tns_torus_shift`

## Requirements
- R1: While rst_ni is low, bits_o is all zeros, and it clears at once when rst_ni falls, without waiting for a clock edge.
- R2: On each rising clock edge bits_o loads the result computed from the bits_i and dir_i present at that edge, and it holds that value until the next edge.
- R3: With direction code 0 (north), output bit r*SIDE+c takes input bit ((r-1) mod SIDE)*SIDE+c.
- R4: With direction code 4 (south), output bit r*SIDE+c takes input bit ((r+1) mod SIDE)*SIDE+c.
- R5: With direction code 2 (east), output bit r*SIDE+c takes input bit r*SIDE+((c+1) mod SIDE).
- R6: With direction code 6 (west), output bit r*SIDE+c takes input bit r*SIDE+((c-1) mod SIDE).
- R7: The diagonal codes each combine one row step and one column step, both wrapping. Code 1 (north-east) uses row-1 and col+1. Code 3 (south-east) uses row+1 and col+1. Code 5 (south-west) uses row+1 and col-1. Code 7 (north-west) uses row-1 and col-1.
- R8: Every move is a permutation, so the number of ones in bits_o equals the number of ones in the bits_i it was built from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the output is captured on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 3 | Direction code of the move |
| bits_i | input | SIDE*SIDE | One bit from each element, in row-major order |
| bits_o | output | SIDE*SIDE | Registered bit received from the selected neighbour |

## Verification
Each result is due exactly one rising edge after its stimulus. The bench drives inputs on the falling edge and compares bits_o on the next falling edge, which is half a period after the capturing edge. For R2, a check taken between the new stimulus and the next rising edge confirms that bits_o still holds the previous result. Reset clearing is checked one nanosecond after rst_ni falls, with no clock edge in between.

// File: rtl/tns_pkg.sv
`timescale 1ns/1ps
package tns_pkg;
  typedef enum logic [2:0] {
    DIR_N  = 3'd0,
    DIR_NE = 3'd1,
    DIR_E  = 3'd2,
    DIR_SE = 3'd3,
    DIR_S  = 3'd4,
    DIR_SW = 3'd5,
    DIR_W  = 3'd6,
    DIR_NW = 3'd7
  } dir_e;

  // DEC: take from the lower row/column index; INC: from the higher one
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_DEC  = 2'd1,
    STEP_INC  = 2'd2
  } step_e;

  typedef struct packed {
    step_e row;
    step_e col;
  } move_t;
endpackage

// File: rtl/tns_dir_decode.sv
`timescale 1ns/1ps
module tns_dir_decode
  import tns_pkg::*;
(
  input  logic [2:0] dir_i,
  output move_t      move_o
);
  always_comb begin
    move_o = '{row: STEP_NONE, col: STEP_NONE};
    unique case (dir_e'(dir_i))
      DIR_N:  move_o = '{row: STEP_DEC,  col: STEP_NONE};
      DIR_NE: move_o = '{row: STEP_DEC,  col: STEP_INC};
      DIR_E:  move_o = '{row: STEP_NONE, col: STEP_INC};
      DIR_SE: move_o = '{row: STEP_INC,  col: STEP_INC};
      DIR_S:  move_o = '{row: STEP_INC,  col: STEP_NONE};
      DIR_SW: move_o = '{row: STEP_INC,  col: STEP_DEC};
      DIR_W:  move_o = '{row: STEP_NONE, col: STEP_DEC};
      DIR_NW: move_o = '{row: STEP_DEC,  col: STEP_DEC};
      default: move_o = '{row: STEP_NONE, col: STEP_NONE};
    endcase
  end
endmodule

// File: rtl/tns_row_shift.sv
`timescale 1ns/1ps
module tns_row_shift
  import tns_pkg::*;
#(
  parameter int SIDE = 4,
  localparam int CELLS = SIDE * SIDE
) (
  input  step_e              step_i,
  input  logic [CELLS-1:0]   bits_i,
  output logic [CELLS-1:0]   bits_o
);
  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      localparam int SELF = r * SIDE + c;
      localparam int UP   = ((r + SIDE - 1) % SIDE) * SIDE + c;
      localparam int DOWN = ((r + 1) % SIDE) * SIDE + c;
      assign bits_o[SELF] = (step_i == STEP_DEC) ? bits_i[UP]   :
                            (step_i == STEP_INC) ? bits_i[DOWN] :
                                                   bits_i[SELF];
    end
  end
endmodule

// File: rtl/tns_col_shift.sv
`timescale 1ns/1ps
module tns_col_shift
  import tns_pkg::*;
#(
  parameter int SIDE = 4,
  localparam int CELLS = SIDE * SIDE
) (
  input  step_e              step_i,
  input  logic [CELLS-1:0]   bits_i,
  output logic [CELLS-1:0]   bits_o
);
  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      localparam int SELF  = r * SIDE + c;
      localparam int LEFT  = r * SIDE + (c + SIDE - 1) % SIDE;
      localparam int RIGHT = r * SIDE + (c + 1) % SIDE;
      assign bits_o[SELF] = (step_i == STEP_DEC) ? bits_i[LEFT]  :
                            (step_i == STEP_INC) ? bits_i[RIGHT] :
                                                   bits_i[SELF];
    end
  end
endmodule

// File: rtl/tns_torus_shift.sv
`timescale 1ns/1ps
module tns_torus_shift
  import tns_pkg::*;
#(
  parameter int SIDE = 4,
  localparam int CELLS = SIDE * SIDE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       dir_i,
  input  logic [CELLS-1:0] bits_i,
  output logic [CELLS-1:0] bits_o
);
  move_t            move;
  logic [CELLS-1:0] row_moved;
  logic [CELLS-1:0] col_moved;

  tns_dir_decode u_dec (
    .dir_i  (dir_i),
    .move_o (move)
  );

  // vertical step first, then horizontal: diagonals fall out of the pair
  tns_row_shift #(.SIDE(SIDE)) u_rows (
    .step_i (move.row),
    .bits_i (bits_i),
    .bits_o (row_moved)
  );

  tns_col_shift #(.SIDE(SIDE)) u_cols (
    .step_i (move.col),
    .bits_i (row_moved),
    .bits_o (col_moved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_o <= '0;
    else         bits_o <= col_moved;
  end
endmodule

// File: rtl/tns_torus_shift_chk.sv
`timescale 1ns/1ps
module tns_torus_shift_chk #(
  parameter int SIDE = 4,
  localparam int CELLS = SIDE * SIDE
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       dir_i,
  input logic [CELLS-1:0] bits_i,
  input logic [CELLS-1:0] bits_o
);
  // vertical moves are whole-vector rotations by one row
  logic [CELLS-1:0] north_ref;
  logic [CELLS-1:0] south_ref;
  assign north_ref = {bits_i[CELLS-SIDE-1:0], bits_i[CELLS-1:CELLS-SIDE]};
  assign south_ref = {bits_i[SIDE-1:0], bits_i[CELLS-1:SIDE]};

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |-> bits_o == '0);

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $stable(bits_i) && $stable(dir_i)) |=> $stable(bits_o));

  assert_north_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(dir_i) == 3'd0) |-> bits_o == $past(north_ref));

  assert_south_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(dir_i) == 3'd4) |-> bits_o == $past(south_ref));

  assert_ones_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $countones(bits_o) == $countones($past(bits_i)));
endmodule

bind tns_torus_shift tns_torus_shift_chk #(.SIDE(SIDE)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dir_i  (dir_i),
  .bits_i (bits_i),
  .bits_o (bits_o)
);

// File: tb/sim_tns_torus_shift.sv
`timescale 1ns/1ps
module sim_tns_torus_shift;
  localparam int SIDE  = 4;
  localparam int CELLS = SIDE * SIDE;
  localparam int NVEC  = 16;

  // {dir, pattern}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 16'h0001}, {3'd0, 16'hA5C3},
    {3'd4, 16'h8000}, {3'd4, 16'h1234},
    {3'd2, 16'h0008}, {3'd2, 16'hF00D},
    {3'd6, 16'h0010}, {3'd6, 16'h6B2E},
    {3'd1, 16'h0001}, {3'd1, 16'h9C41},
    {3'd3, 16'h8000}, {3'd3, 16'h3F70},
    {3'd5, 16'h1000}, {3'd5, 16'hD00B},
    {3'd7, 16'h0008}, {3'd7, 16'h5EA7}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       dir = 3'd0;
  logic [CELLS-1:0] bits_in = '0;
  logic [CELLS-1:0] bits_out;
  int               n_chk = 0;
  int               n_err = 0;
  bit               done = 1'b0;

  always #4 clk = ~clk;

  tns_torus_shift #(.SIDE(SIDE)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .dir_i  (dir),
    .bits_i (bits_in),
    .bits_o (bits_out)
  );

  function automatic logic [CELLS-1:0] ref_move(input logic [2:0] d, input logic [CELLS-1:0] v);
    int dr, dc;
    logic [CELLS-1:0] o;
    case (d)
      3'd0: begin dr = -1; dc =  0; end
      3'd1: begin dr = -1; dc =  1; end
      3'd2: begin dr =  0; dc =  1; end
      3'd3: begin dr =  1; dc =  1; end
      3'd4: begin dr =  1; dc =  0; end
      3'd5: begin dr =  1; dc = -1; end
      3'd6: begin dr =  0; dc = -1; end
      default: begin dr = -1; dc = -1; end
    endcase
    for (int r = 0; r < SIDE; r++)
      for (int c = 0; c < SIDE; c++)
        o[r*SIDE+c] = v[((r + dr + SIDE) % SIDE) * SIDE + (c + dc + SIDE) % SIDE];
    return o;
  endfunction

  function automatic string tag_of(input logic [2:0] d);
    case (d)
      3'd0: return "R3";
      3'd4: return "R4";
      3'd2: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] d, input logic [CELLS-1:0] v);
    dir = d;
    bits_in = v;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CELLS-1:0] prev;
    repeat (3) @(negedge clk);
    check("R1 reset value", bits_out, '0);
    apply(3'd2, 16'hFFFF);
    @(negedge clk);
    check("R1 held in reset", bits_out, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][18:16], VEC[i][15:0]);
      @(negedge clk);
      check(tag_of(VEC[i][18:16]), bits_out, ref_move(VEC[i][18:16], VEC[i][15:0]));
    end

    // corner single bits exercise wrap in every direction
    for (int d = 0; d < 8; d++) begin
      apply(3'(d), 16'h0001);
      @(negedge clk);
      check(tag_of(3'(d)), bits_out, ref_move(3'(d), 16'h0001));
      apply(3'(d), 16'h8000);
      @(negedge clk);
      check(tag_of(3'(d)), bits_out, ref_move(3'(d), 16'h8000));
    end

    // R2: output holds until the capturing edge, then updates
    prev = bits_out;
    apply(3'd6, 16'h0F0F);
    #2;
    check("R2 before edge", bits_out, prev);
    @(negedge clk);
    check("R2 after edge", bits_out, ref_move(3'd6, 16'h0F0F));

    // R8: ones count preserved
    apply(3'd3, 16'h1357);
    @(negedge clk);
    check("R8 ones count", 16'($countones(bits_out)), 16'($countones(16'h1357)));

    // north then south returns original (R3, R4)
    apply(3'd0, 16'hC0DE);
    @(negedge clk);
    apply(3'd4, bits_out);
    @(negedge clk);
    check("R3 R4 round trip", bits_out, 16'hC0DE);

    // R1: asynchronous clear mid-run
    apply(3'd1, 16'hFFFF);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", bits_out, '0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule